// File: doc/BRIEF.md
# SPI memory slave front end with hold pause

This block is the serial interface of a memory-style SPI slave running in SPI mode 0. A fast system clock oversamples the serial clock, the active-low select, the active-low pause input and the serial data input through synchronisers. Edges of the serial clock are found in the system domain. Instruction and data bits are captured MSB first on rising serial clock edges. Response bits move onto the output on falling edges.

A small instruction set is decoded:

- a status read returns a status byte, repeatedly;
- an identification read returns a fixed byte, repeatedly;
- a status write takes exactly one data byte;
- a long-operation start takes no data.

The two write-type commands take effect when the chip is deselected. They then hold a busy flag for a fixed number of system cycles. This models a long internal operation.

The pause input lets the master stop a transfer half way through and resume it later at the very next bit. The pause starts and ends only while the serial clock is low. A pause edge that arrives while the clock is high takes effect when the clock next goes low. While paused:

- the output enable is dropped;
- clock and data activity is ignored;
- the busy timer keeps running.

Deselecting during a pause clears the interface and commits nothing. The interface then stays locked until the pause input is high while deselected.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset `miso_oe` is 0, and the first status read (instruction 8'h05) returns 8'h00.
- R2: Input bits are taken on rising `sclk` edges, MSB first. After instruction 8'h05, each following byte carries the status byte MSB first. Status bits [7:1] are the stored bits and bit 0 is busy. Output bits change only on falling `sclk` edges.
- R3: After instruction 8'h9F, every following byte is `ID_BYTE` (default 8'hC3).
- R4: Instruction 8'h01 followed by exactly one data byte and then a deselect stores data bits [7:1] into status bits [7:1] and starts busy. Any other byte count stores nothing.
- R5: Instruction 8'h20 alone followed by a deselect starts busy for `BUSY_CYCLES` system cycles. Write-type commands that end while busy is set are ignored.
- R6: `miso_oe` is 1 only while selected, not paused and not locked.
- R7: A falling `hold_n` while `sclk` is low starts the pause within four system cycles. The start is seen as `miso_oe` going 0.
- R8: A falling `hold_n` while `sclk` is high leaves `miso_oe` at 1 until `sclk` next falls. That falling edge still advances the output bit.
- R9: A rising `hold_n` while `sclk` is low ends the pause at once. While `sclk` is high, the pause ends only when `sclk` next falls, and that falling edge is not counted.
- R10: During a pause, `sclk` and `mosi` activity is ignored. The bit position and shift registers are kept, so the transfer resumes at the next bit.
- R11: The busy timer keeps counting during a pause.
- R12: A deselect during a pause clears the bit position and shift registers and commits no command. Until `hold_n` is high while `cs_n` is high, `miso_oe` stays 0 and serial input is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause request |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the external pad driver; 0 means high impedance |

## Verification
Every result is due a fixed number of system cycles after the serial-side event that causes it. A change on a serial input passes two synchroniser stages and one registered decision. `miso` and `miso_oe` therefore settle no more than four system cycles after the edge. The bench drives serial edges eight system cycles apart and samples `miso` just before it raises `sclk`. It checks `miso_oe` six cycles after each pause or select change, which also lets it see that a deferred pause has not yet taken effect. The busy period lasts `BUSY_CYCLES` = 1000 cycles. Reads meant to see busy set are started well inside that window, and reads meant to see it clear wait 1200 cycles or more.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_ID   = 8'h9F;
  localparam logic [7:0] OP_LONG    = 8'h20;

  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic hold_n;
    logic mosi;
  } pins_t;

  function automatic logic is_read_op(input logic [7:0] op);
    return (op == OP_RD_STAT) || (op == OP_RD_ID);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {NS{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < NS; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[NS-1];
endmodule

// File: rtl/spi_busy_timer.sv
module spi_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start)          cnt <= CW'(CYCLES);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == CW'(CYCLES)));

  // R11
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic run,
  output logic commit,
  output logic oe
);
  logic paused;
  logic locked;
  logic cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      paused  <= 1'b0;
      locked  <= 1'b0;
      cs_prev <= 1'b1;
      oe      <= 1'b0;
    end else begin
      cs_prev <= cs_n_s;
      oe      <= ~cs_n_s & ~locked & ~paused;
      if (cs_n_s) begin
        paused <= 1'b0;
        if (paused)        locked <= 1'b1;
        else if (hold_n_s) locked <= 1'b0;
      end else if (!locked && !sclk_s) begin
        if (!paused && !hold_n_s)     paused <= 1'b1;
        else if (paused && hold_n_s)  paused <= 1'b0;
      end
    end
  end

  assign run    = ~cs_n_s & ~locked & ~paused;
  assign commit = cs_n_s & ~cs_prev & ~paused & ~locked;

  // R7
  pause_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(paused) && !$past(cs_n_s)) |-> !$past(sclk_s));

  // R6
  oe_desel_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !oe);

  // R12
  lock_no_pause_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> !paused);

  // R12
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && cs_n_s && hold_n_s) |=> !locked);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_hold_pkg::*;
#(
  parameter logic [7:0] ID_BYTE = 8'hC3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic mosi,
  input  logic commit,
  input  logic busy,
  output logic start_busy,
  output logic miso_bit
);
  logic [2:0] bit_idx;
  logic [1:0] byte_cnt;
  logic [7:0] rx_sr;
  logic [7:0] opcode;
  logic [7:0] data_byte;
  logic [7:0] tx_sr;
  logic [7:1] stat_bits;
  logic [7:0] rx_next;
  logic [7:0] resp;

  assign rx_next = {rx_sr[6:0], mosi};
  assign resp    = (opcode == OP_RD_ID) ? ID_BYTE : {stat_bits, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx    <= '0;
      byte_cnt   <= '0;
      rx_sr      <= '0;
      opcode     <= '0;
      data_byte  <= '0;
      tx_sr      <= '0;
      stat_bits  <= '0;
      start_busy <= 1'b0;
    end else begin
      start_busy <= 1'b0;
      if (commit && !busy && bit_idx == 3'd0) begin
        if (opcode == OP_WR_STAT && byte_cnt == 2'd2) begin
          stat_bits  <= data_byte[7:1];
          start_busy <= 1'b1;
        end else if (opcode == OP_LONG && byte_cnt == 2'd1) begin
          start_busy <= 1'b1;
        end
      end
      if (clr) begin
        bit_idx   <= '0;
        byte_cnt  <= '0;
        rx_sr     <= '0;
        opcode    <= '0;
        data_byte <= '0;
        tx_sr     <= '0;
      end else begin
        if (run && sclk_rise) begin
          rx_sr   <= rx_next;
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) begin
            if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
            if (byte_cnt == 2'd0) opcode <= rx_next;
            if (byte_cnt == 2'd1) data_byte <= rx_next;
          end
        end
        if (run && sclk_fall) begin
          if (byte_cnt != 2'd0 && bit_idx == 3'd0 && is_read_op(opcode))
            tx_sr <= resp;
          else
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign miso_bit = tx_sr[7];

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> ($stable(bit_idx) && $stable(rx_sr) && $stable(tx_sr)));

  // R2
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_sr) && !$past(clr)) |-> $past(sclk_fall));

  // R4
  stat_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_bits) |-> $past(commit));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 1000,
  parameter logic [7:0] ID_BYTE = 8'hC3
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic hold_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int PW = $bits(pins_t);
  localparam pins_t PIN_IDLE = '{sclk: 1'b0, cs_n: 1'b1, hold_n: 1'b1, mosi: 1'b0};

  pins_t raw_pins;
  pins_t syn_pins;
  logic  sclk_prev;
  logic  run, commit, busy, start_busy;
  logic  sclk_rise, sclk_fall;

  assign raw_pins = '{sclk: sclk, cs_n: cs_n, hold_n: hold_n, mosi: mosi};

  spi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(syn_pins)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= syn_pins.sclk;
  end

  assign sclk_rise = syn_pins.sclk & ~sclk_prev;
  assign sclk_fall = ~syn_pins.sclk & sclk_prev;

  spi_hold_ctrl u_hold (
    .clk(clk), .rst(rst),
    .sclk_s(syn_pins.sclk), .cs_n_s(syn_pins.cs_n), .hold_n_s(syn_pins.hold_n),
    .run(run), .commit(commit), .oe(miso_oe)
  );

  spi_shift_core #(.ID_BYTE(ID_BYTE)) u_core (
    .clk(clk), .rst(rst), .clr(syn_pins.cs_n), .run(run),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(syn_pins.mosi),
    .commit(commit), .busy(busy), .start_busy(start_busy), .miso_bit(miso)
  );

  spi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(start_busy), .busy(busy)
  );

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_busy |=> busy);
endmodule

// File: tb/spi_hold_slave_bench.sv
module spi_hold_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int SETTLE = 6;

  logic clk = 0, rst = 1;
  logic sclk = 0, cs_n = 1, hold_n = 1, mosi = 0;
  logic miso, miso_oe;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { string req; logic [7:0] val; } item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_slave u_spi_hold_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] v);
    item_t it;
    it.req = req; it.val = v;
    exp_q.push_back(it);
  endtask

  // monitor: pairs produced bytes with expected ones in order
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0 && got_q.size() != 0) begin
        item_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        chk(g == e.val, e.req, g, e.val);
      end
    end
  end

  task automatic clk_bit(input logic b, output logic r);
    mosi = b;
    wait_n(HALF);
    r = miso;
    sclk = 1;
    wait_n(HALF);
    sclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
  endtask

  task automatic read_bits(input int n, inout logic [7:0] v);
    logic r;
    for (int i = 0; i < n; i++) begin
      clk_bit(1'b0, r);
      v = {v[6:0], r};
    end
  endtask

  task automatic read_byte();
    logic [7:0] v = '0;
    read_bits(8, v);
    got_q.push_back(v);
  endtask

  task automatic sel();
    cs_n = 0;
    wait_n(HALF);
  endtask

  task automatic desel();
    wait_n(HALF);
    cs_n = 1;
    wait_n(3*HALF);
  endtask

  task automatic rd_status(input string req, input logic [7:0] exp);
    expect_byte(req, exp);
    sel(); send_byte(8'h05); read_byte(); desel();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    wait_n(5);
    rst = 0;
    wait_n(5);
    chk(miso_oe == 0, "R1 oe after reset", miso_oe, 0);
    rd_status("R1 status after reset", 8'h00);

    // R6 and R3
    expect_byte("R3 id byte 1", 8'hC3);
    expect_byte("R3 id byte 2 R2 repeat", 8'hC3);
    sel();
    wait_n(SETTLE);
    chk(miso_oe == 1, "R6 oe selected", miso_oe, 1);
    send_byte(8'h9F); read_byte(); read_byte();
    desel();
    chk(miso_oe == 0, "R6 oe deselected", miso_oe, 0);

    // R4 status write, busy visible, write during busy ignored (R5)
    sel(); send_byte(8'h01); send_byte(8'hA5); desel();
    rd_status("R4 status while busy", 8'hA5);
    sel(); send_byte(8'h01); send_byte(8'h00); desel();
    wait_n(1200);
    rd_status("R5 write while busy ignored / R4 stored", 8'hA4);

    // R4 wrong byte count
    sel(); send_byte(8'h01); send_byte(8'h3C); send_byte(8'h00); desel();
    wait_n(1200);
    rd_status("R4 extra byte ignored", 8'hA4);

    // R5 long operation
    sel(); send_byte(8'h20); desel();
    rd_status("R5 long op busy", 8'hA5);
    wait_n(1200);
    rd_status("R5 long op done", 8'hA4);

    // R7, R9 immediate, R10 resume
    expect_byte("R10 resume after pause", 8'hA4);
    sel(); send_byte(8'h05);
    v = '0;
    read_bits(3, v);
    hold_n = 0;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R7 pause with sclk low", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      mosi = 1; sclk = 1; wait_n(HALF); sclk = 0; wait_n(HALF);
    end
    hold_n = 1;
    wait_n(SETTLE);
    chk(miso_oe == 1, "R9 release with sclk low", miso_oe, 1);
    read_bits(5, v);
    got_q.push_back(v);
    desel();

    // R8, R9 deferred
    expect_byte("R8 R9 deferred pause byte", 8'hA4);
    sel(); send_byte(8'h05);
    v = '0;
    read_bits(4, v);
    mosi = 0;
    wait_n(HALF);
    v = {v[6:0], miso};
    sclk = 1;
    wait_n(HALF);
    hold_n = 0;
    wait_n(SETTLE);
    chk(miso_oe == 1, "R8 pause deferred while sclk high", miso_oe, 1);
    sclk = 0;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R8 pause starts at sclk low", miso_oe, 0);
    sclk = 1;
    wait_n(HALF);
    hold_n = 1;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R9 release deferred while sclk high", miso_oe, 0);
    sclk = 0;
    wait_n(SETTLE);
    chk(miso_oe == 1, "R9 release at sclk low", miso_oe, 1);
    read_bits(3, v);
    got_q.push_back(v);
    desel();

    // R11 busy keeps counting through a pause
    sel(); send_byte(8'h20); desel();
    expect_byte("R11 busy before pause", 8'hA5);
    expect_byte("R11 busy ended during pause", 8'hA4);
    sel(); send_byte(8'h05);
    v = '0;
    read_bits(2, v);
    hold_n = 0;
    wait_n(1300);
    hold_n = 1;
    wait_n(SETTLE);
    read_bits(6, v);
    got_q.push_back(v);
    read_byte();
    desel();

    // R12 deselect during pause
    sel(); send_byte(8'h01);
    v = '0;
    read_bits(4, v);
    hold_n = 0;
    wait_n(SETTLE);
    cs_n = 1;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R12 oe after deselect in pause", miso_oe, 0);
    cs_n = 0;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R12 locked while pause held", miso_oe, 0);
    send_byte(8'h05);
    hold_n = 1;
    wait_n(SETTLE);
    chk(miso_oe == 0, "R12 stays locked until deselect", miso_oe, 0);
    cs_n = 1;
    wait_n(3*HALF);
    rd_status("R12 nothing committed, fresh bit count", 8'hA4);

    wait_n(40);
    chk(exp_q.size() == 0 && got_q.size() == 0, "scoreboard drained",
        exp_q.size() + got_q.size(), 0);
    finish_run();
  end
endmodule